// File: doc/BRIEF.md
# Cosine Operand Classifier and Write-Back Control

This block sits in front of a floating-point cosine datapath. It works on the 80-bit extended-precision top-of-stack register. When a start request arrives, it sorts the operand into a class: empty register, invalid encoding, quiet NaN, zero, out of range, or ordinary finite value. It then decides how the result is produced.

Special classes get a forced result in the cycle after the request, and the datapath is never started for them. An out-of-range operand leaves the register as it was and reports the condition through condition bit C2 instead of raising an exception. An ordinary finite operand, denormals included, is passed to the external cosine datapath through a start/done handshake. The result, the rounded-up indication and the inexact indication are forwarded in the cycle the datapath reports completion.

Operand layout: sign at bit 79, a 15-bit biased exponent at bits 78:64 with bias 16383, and a 64-bit significand with an explicit integer bit at bit 63. The core uses `done_o` together with `wr_en_o`, `res_o`, `c_o` and the four exception flags to update the register and the status word.

Top module: `cosine_frontend`

## Requirements
- R1: After reset, `done_o`, `dp_start_o` and `busy_o` are 0.
- R2: An operand with a finite biased exponent of 16446 or more gives `done_o` one cycle after the accepted start, with C2 (`c_o[2]`) = 1, `wr_en_o` = 0 and all exception flags clear. An exponent of 16445 goes to the datapath.
- R3: For a finite nonzero operand that is in range, `dp_start_o` is 1 in the cycle of the accepted start, and `dp_arg_o` equals the operand. `done_o` and `wr_en_o` are 1, C2 is 0 and `res_o` equals `dp_res_i` in exactly the cycle that `dp_done_i` is 1.
- R4: On datapath completion, C1 (`c_o[1]`) equals `dp_roundup_i` and the precision flag `fl_p_o` equals `dp_inexact_i`.
- R5: A zero of either sign writes exactly +1 (sign 0, exponent 3FFFh, significand 8000_0000_0000_0000h) one cycle after start, without starting the datapath.
- R6: An infinity of either sign, or an unsupported encoding (nonzero exponent with bit 63 clear), sets `fl_ia_o` and writes the indefinite value (sign 1, exponent 7FFFh, significand C000_0000_0000_0000h).
- R7: A signalling NaN (exponent 7FFFh, bit 63 set, bit 62 clear, nonzero fraction) sets `fl_ia_o` and writes the operand with bit 62 set.
- R8: A quiet NaN (exponent 7FFFh, bits 63 and 62 set) writes the operand unchanged and raises no flag.
- R9: A denormal operand (exponent 0, nonzero significand) goes through the datapath and sets `fl_d_o` on completion.
- R10: With `empty_i` = 1, the block sets `fl_is_o`, clears C1, writes the indefinite value and starts no datapath, whatever the operand is.
- R11: A start request while `busy_o` is 1 is ignored: it starts no datapath and produces no extra completion.
- R12: C0 and C3 (`c_o[0]`, `c_o[3]`) are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to execute the cosine |
| empty_i | input | 1 | Top-of-stack register is empty |
| op_i | input | 80 | Top-of-stack operand |
| dp_start_o | output | 1 | Start pulse to the cosine datapath |
| dp_arg_o | output | 80 | Argument to the datapath |
| dp_done_i | input | 1 | Datapath completion |
| dp_res_i | input | 80 | Datapath result |
| dp_inexact_i | input | 1 | Datapath result is inexact |
| dp_roundup_i | input | 1 | Datapath result was rounded up |
| busy_o | output | 1 | An operation is in flight |
| done_o | output | 1 | Completion pulse; the fields below are valid |
| wr_en_o | output | 1 | Write `res_o` back to the register |
| res_o | output | 80 | Value to write back |
| c_o | output | 4 | Condition codes C3..C0 |
| fl_is_o | output | 1 | Stack underflow flag |
| fl_ia_o | output | 1 | Invalid operand flag |
| fl_d_o | output | 1 | Denormal operand flag |
| fl_p_o | output | 1 | Precision flag |

## Verification
Operands are taken from every class, and each class is checked to select its own result, write enable and flags:
- normal values and both zeros
- both infinities and pseudo-infinity
- unnormal encodings
- signalling and quiet NaNs
- a denormal
- exponents one below and exactly at the range limit

Finite values are run with datapath latencies of one and several cycles and with every rounded-up/inexact combination. This separates the forced one-cycle path from the handshake path and confirms that C1 and P track the datapath. Empty-register cases use an infinity and a finite value, so that underflow is seen to take priority over both the invalid path and the datapath. A start issued mid-operation shows that a busy block ignores it.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int EW = 15;
  localparam int MW = 64;
  localparam int W = 1 + EW + MW;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int RANGE_EXP = BIAS + MW - 1;

  localparam logic [W-1:0] ONE_VAL = {1'b0, EW'(BIAS), 1'b1, {(MW-1){1'b0}}};
  localparam logic [W-1:0] INDEF_VAL = {1'b1, {EW{1'b1}}, 2'b11, {(MW-2){1'b0}}};

  typedef enum logic [2:0] {
    K_EMPTY,
    K_INVALID,
    K_QNAN,
    K_ZERO,
    K_BIG,
    K_FINITE
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FORCE,
    ST_WAIT
  } state_e;
endpackage

// File: rtl/cos_classify.sv
module cos_classify
  import cos_pkg::*;
(
  input  logic [W-1:0] op_i,
  input  logic         empty_i,
  output kind_e        kind_o,
  output logic         denorm_o,
  output logic [W-1:0] forced_o
);
  logic [EW-1:0] ex;
  logic          ib, qb, all1, frac_nz, sig_nz;
  logic          unsup, inf, snan, qnan, zero, big;

  assign ex      = op_i[W-2:MW];
  assign ib      = op_i[MW-1];
  assign qb      = op_i[MW-2];
  assign all1    = &ex;
  assign frac_nz = |op_i[MW-2:0];
  assign sig_nz  = ib | frac_nz;

  assign unsup = (ex != '0) && !ib;
  assign inf   = all1 && ib && !frac_nz;
  assign snan  = all1 && ib && !qb && frac_nz;
  assign qnan  = all1 && ib && qb;
  assign zero  = (ex == '0) && !sig_nz;
  assign big   = ex >= EW'(RANGE_EXP);

  always_comb begin
    denorm_o = 1'b0;
    forced_o = op_i;
    if (empty_i) begin
      kind_o   = K_EMPTY;
      forced_o = INDEF_VAL;
    end else if (unsup || inf || snan) begin
      kind_o   = K_INVALID;
      forced_o = snan ? (op_i | (W'(1) << (MW - 2))) : INDEF_VAL;
    end else if (qnan) begin
      kind_o = K_QNAN;
    end else if (zero) begin
      kind_o   = K_ZERO;
      forced_o = ONE_VAL;
    end else if (big) begin
      kind_o = K_BIG;
    end else begin
      kind_o   = K_FINITE;
      denorm_o = (ex == '0);
    end
  end
endmodule

// File: rtl/cos_ctrl.sv
module cos_ctrl
  import cos_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  kind_e        kind_i,
  input  logic         denorm_i,
  input  logic [W-1:0] forced_i,
  output logic         dp_start_o,
  input  logic         dp_done_i,
  input  logic [W-1:0] dp_res_i,
  input  logic         dp_inexact_i,
  input  logic         dp_roundup_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         wr_en_o,
  output logic [W-1:0] res_o,
  output logic [3:0]   c_o,
  output logic         fl_is_o,
  output logic         fl_ia_o,
  output logic         fl_d_o,
  output logic         fl_p_o
);
  state_e       st;
  logic         accept, in_dp;
  logic [W-1:0] r_res;
  logic         r_wr, r_c2, r_is, r_ia, r_d;

  assign accept     = start_i && (st == ST_IDLE);
  assign dp_start_o = accept && (kind_i == K_FINITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st    <= ST_IDLE;
      r_res <= '0;
      r_wr  <= 1'b0;
      r_c2  <= 1'b0;
      r_is  <= 1'b0;
      r_ia  <= 1'b0;
      r_d   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          r_res <= forced_i;
          r_wr  <= kind_i != K_BIG;
          r_c2  <= kind_i == K_BIG;
          r_is  <= kind_i == K_EMPTY;
          r_ia  <= kind_i == K_INVALID;
          r_d   <= denorm_i && (kind_i == K_FINITE);
          st    <= (kind_i == K_FINITE) ? ST_WAIT : ST_FORCE;
        end
        ST_FORCE: st <= ST_IDLE;
        ST_WAIT:  if (dp_done_i) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign in_dp   = st == ST_WAIT;
  assign busy_o  = st != ST_IDLE;
  assign done_o  = (st == ST_FORCE) || (in_dp && dp_done_i);
  assign wr_en_o = done_o && (in_dp || r_wr);
  assign res_o   = !done_o ? '0 : (in_dp ? dp_res_i : r_res);
  assign c_o     = {1'b0, done_o && r_c2, done_o && in_dp && dp_roundup_i, 1'b0};
  assign fl_is_o = done_o && r_is;
  assign fl_ia_o = done_o && r_ia;
  assign fl_d_o  = done_o && r_d;
  assign fl_p_o  = done_o && in_dp && dp_inexact_i;

  a_r2_c2_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && c_o[2]) |-> !wr_en_o);
  a_r5_forced_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !dp_start_o) |=> done_o);
  a_r3_done_tracks_dp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_start_o |=> (done_o == dp_done_i));
  a_r10_is_clears_c1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fl_is_o) |-> (!c_o[1] && !fl_ia_o));
  a_r6_ia_gives_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fl_ia_o) |-> ((&res_o[W-2:MW]) && res_o[MW-1] && res_o[MW-2]));
  a_r12_c0_c3_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!c_o[0] && !c_o[3]));
endmodule

// File: rtl/cosine_frontend.sv
module cosine_frontend
  import cos_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         empty_i,
  input  logic [79:0]  op_i,
  output logic         dp_start_o,
  output logic [79:0]  dp_arg_o,
  input  logic         dp_done_i,
  input  logic [79:0]  dp_res_i,
  input  logic         dp_inexact_i,
  input  logic         dp_roundup_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         wr_en_o,
  output logic [79:0]  res_o,
  output logic [3:0]   c_o,
  output logic         fl_is_o,
  output logic         fl_ia_o,
  output logic         fl_d_o,
  output logic         fl_p_o
);
  kind_e        kind;
  logic         denorm;
  logic [W-1:0] forced;

  assign dp_arg_o = op_i;

  cos_classify u_cls (
    .op_i     (op_i),
    .empty_i  (empty_i),
    .kind_o   (kind),
    .denorm_o (denorm),
    .forced_o (forced)
  );

  cos_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .kind_i       (kind),
    .denorm_i     (denorm),
    .forced_i     (forced),
    .dp_start_o   (dp_start_o),
    .dp_done_i    (dp_done_i),
    .dp_res_i     (dp_res_i),
    .dp_inexact_i (dp_inexact_i),
    .dp_roundup_i (dp_roundup_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .wr_en_o      (wr_en_o),
    .res_o        (res_o),
    .c_o          (c_o),
    .fl_is_o      (fl_is_o),
    .fl_ia_o      (fl_ia_o),
    .fl_d_o       (fl_d_o),
    .fl_p_o       (fl_p_o)
  );
endmodule

// File: tb/cosine_frontend_tb.sv
`timescale 1ns/1ps
module cosine_frontend_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, empty = 1'b0, dp_done = 1'b0, dp_inex = 1'b0, dp_rup = 1'b0;
  logic [79:0] op = '0, dp_res = '0;
  logic        dp_start, busy, done, wr_en, f_is, f_ia, f_d, f_p;
  logic [79:0] dp_arg, res;
  logic [3:0]  c;
  int checks = 0, failures = 0;
  bit finished = 0;

  localparam logic [79:0] ONE   = 80'h3FFF_8000_0000_0000_0000;
  localparam logic [79:0] INDEF = 80'hFFFF_C000_0000_0000_0000;

  always #2.5 clk = ~clk;

  cosine_frontend u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .empty_i(empty), .op_i(op),
    .dp_start_o(dp_start), .dp_arg_o(dp_arg), .dp_done_i(dp_done), .dp_res_i(dp_res),
    .dp_inexact_i(dp_inex), .dp_roundup_i(dp_rup), .busy_o(busy), .done_o(done),
    .wr_en_o(wr_en), .res_o(res), .c_o(c), .fl_is_o(f_is), .fl_ia_o(f_ia),
    .fl_d_o(f_d), .fl_p_o(f_p)
  );

  task automatic chk(input string tag, input string what, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle_chk(input string tag);
    chk(tag, "done idle", 80'(done), 80'(0));
    chk(tag, "wr idle", 80'(wr_en), 80'(0));
  endtask

  // behavioural reference: classify with integer arithmetic, then run one operation
  task automatic run(input logic [79:0] v, input bit emp, input int lat,
                     input bit rup, input bit inex, input bit poke_busy);
    int e = int'(v[78:64]);
    bit ib = v[63];
    bit frac = v[62:0] != 0;
    bit use_dp = 0, x_wr = 1, x_c2 = 0, x_is = 0, x_ia = 0, x_d = 0;
    logic [79:0] x_res = v;
    logic [79:0] pat = {v[79:40] ^ 40'h5A5A_A5A5_33, v[39:0]};
    string tag;
    if (emp) begin tag = "R10"; x_is = 1; x_res = INDEF; end
    else if (e == 32767 && ib && !frac) begin tag = "R6"; x_ia = 1; x_res = INDEF; end
    else if (e != 0 && !ib) begin tag = "R6"; x_ia = 1; x_res = INDEF; end
    else if (e == 32767 && !v[62]) begin tag = "R7"; x_ia = 1; x_res = v | (80'd1 << 62); end
    else if (e == 32767) tag = "R8";
    else if (e == 0 && !ib && !frac) begin tag = "R5"; x_res = ONE; end
    else if (e > 16445) begin tag = "R2"; x_c2 = 1; x_wr = 0; end
    else begin tag = (e == 0) ? "R9" : "R3"; use_dp = 1; x_d = (e == 0); x_res = pat; end

    @(negedge clk);
    op = v; empty = emp; start = 1;
    #1;
    chk(tag, "dp_start", 80'(dp_start), 80'(use_dp));
    if (use_dp) chk("R3", "dp_arg", dp_arg, v);
    idle_chk(tag);
    @(negedge clk);
    start = 0;
    if (use_dp) begin
      for (int k = 1; k < lat; k++) begin
        if (poke_busy && k == 1) begin
          start = 1; op = 80'h0;
          #1;
          chk("R11", "dp_start while busy", 80'(dp_start), 80'(0));
          idle_chk("R11");
          @(negedge clk);
          start = 0;
        end else begin
          #1; idle_chk(tag);
          @(negedge clk);
        end
      end
      dp_done = 1; dp_res = pat; dp_rup = rup; dp_inex = inex;
    end
    #1;
    chk(tag, "done", 80'(done), 80'(1));
    chk(tag, "wr_en", 80'(wr_en), 80'(x_wr));
    if (x_wr) chk(tag, "res", res, x_res);
    chk(tag, "C2", 80'(c[2]), 80'(x_c2));
    if (!x_c2) chk(use_dp ? "R4" : tag, "C1", 80'(c[1]), 80'(use_dp ? rup : 1'b0));
    chk("R12", "C0/C3", 80'({c[3], c[0]}), 80'(0));
    chk(tag, "IS", 80'(f_is), 80'(x_is));
    chk(tag, "IA", 80'(f_ia), 80'(x_ia));
    chk("R9", "D", 80'(f_d), 80'(x_d));
    chk("R4", "P", 80'(f_p), 80'(use_dp ? inex : 1'b0));
    @(negedge clk);
    dp_done = 0; dp_rup = 0; dp_inex = 0;
    #1; idle_chk(poke_busy ? "R11" : tag);
    chk(tag, "busy after", 80'(busy), 80'(0));
  endtask

  initial begin
    #12;
    chk("R1", "done reset", 80'(done), 80'(0));
    chk("R1", "dp_start reset", 80'(dp_start), 80'(0));
    chk("R1", "busy reset", 80'(busy), 80'(0));
    @(negedge clk); rst_n = 1;
    run(80'h3FFF_8000_0000_0000_0000, 0, 3, 1, 1, 0);  // R3 R4
    run(80'hC000_C90F_DAA2_2168_C235, 0, 1, 0, 0, 0);  // R4
    run(80'h3FFE_8000_0000_0000_0000, 0, 2, 1, 0, 0);
    run(80'h0000_0000_0000_0000_0000, 0, 1, 0, 0, 0);  // R5
    run(80'h8000_0000_0000_0000_0000, 0, 1, 0, 0, 0);  // R5
    run(80'h7FFF_8000_0000_0000_0000, 0, 1, 0, 0, 0);  // R6
    run(80'hFFFF_8000_0000_0000_0000, 0, 1, 0, 0, 0);  // R6
    run(80'h4000_4000_0000_0000_0000, 0, 1, 0, 0, 0);  // R6 unnormal
    run(80'h7FFF_0000_0000_0000_0000, 0, 1, 0, 0, 0);  // R6 pseudo-infinity
    run(80'h7FFF_8000_0000_0000_0001, 0, 1, 0, 0, 0);  // R7
    run(80'hFFFF_C000_0000_0000_1234, 0, 1, 0, 0, 0);  // R8
    run(80'h0000_0000_0000_0000_0001, 0, 2, 0, 1, 0);  // R9
    run(80'h403D_FFFF_FFFF_FFFF_FFFF, 0, 1, 1, 1, 0);  // R2 boundary below
    run(80'h403E_8000_0000_0000_0000, 0, 1, 0, 0, 0);  // R2 at limit
    run(80'hC100_8000_0000_0000_0000, 0, 1, 0, 0, 0);  // R2
    run(80'h7FFF_8000_0000_0000_0000, 1, 1, 0, 0, 0);  // R10 over invalid
    run(80'h3FFF_8000_0000_0000_0000, 1, 1, 0, 0, 0);  // R10 over datapath
    run(80'h3FFF_A000_0000_0000_0000, 0, 4, 0, 1, 1);  // R11
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule